// File: doc/BRIEF.md
# Operand Reuse Read Controller

This block sits in the decode stage of a five-stage RISC pipeline, in front of a 32-entry register file that has two read ports and one write port. For every decoded instruction it receives the two source register numbers, a flag per source telling whether that source is used, and an instruction-valid flag. It also sees the register file write port (enable and address). It keeps a small history of the operand values that the two previous instructions consumed, each tagged with its register number. When a source register of the current instruction is already held in that history and has not been written since, the block drops the register file read for that port and steers the held value to the ALU input instead.

Three reuse paths are checked in a fixed order. The first is the same port of the previous instruction. The second is the opposite port of the previous instruction, which feeds the value across. The third is the instruction two positions back, on either port, which lets a value survive across one intervening instruction such as a load. The crossed path and the two-back path are build-time options, so a reduced controller can be compared with the full one. A 32-bit counter totals the register file reads that are actually issued. Register 0 is the constant zero and is never read.

The register file answers a read in the same cycle (`rf_rdata_*` depends combinationally on the source number). A write on the write port in the same cycle is not visible through that read.

Top module: `orr_read_ctrl`

## Requirements
- R1: After reset the read counter is 0 and the history is empty, so the first valid instruction reads every used non-zero source from the register file.
- R2: A source that is unused, is register 0, or belongs to a cycle with `in_valid` low gives select code 4, no read enable, and an operand of 0.
- R3: If a source equals the same-port source of the previous valid instruction, and that register has not been written since, including in the current cycle, the port gives select code 1, issues no read, and outputs the value that the previous instruction consumed on that port.
- R4: With `EN_SWAP`=1, if R3 does not apply and the source equals the opposite-port source of the previous valid instruction under the same no-write condition, the port gives select code 2 and outputs that opposite-port value without a read.
- R5: With `EN_BACK2`=1, if neither R3 nor R4 applies, a match with the instruction two valid positions back gives select code 3 (same port) or 5 (opposite port) and no read.
- R6: When several paths match, the priority is code 1, then 2, then 3, then 5.
- R7: A write to a register removes every held copy of it. A source written in the current cycle, or written after its copy was taken, is read from the register file (select code 0, read enable high, operand = `rf_rdata`).
- R8: Cycles with `in_valid` low issue no reads and leave the history unchanged, apart from removals caused by writes.
- R9: `read_count` increases by exactly the number of read enables asserted in each cycle.
- R10: For the six-instruction sequence (17,9), (17,9), (9,17), (17,9), (17,unused), (17,9) with no writes, the counter ends at 7 with both options off, 3 with only `EN_SWAP`, and 2 with both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present this cycle |
| use_a | input | 1 | First source is used |
| src_a | input | 5 | First source register number |
| use_b | input | 1 | Second source is used |
| src_b | input | 5 | Second source register number |
| wr_en | input | 1 | Register file write this cycle |
| wr_addr | input | 5 | Register number being written |
| rf_rdata_a | input | 32 | Register file read data, first port |
| rf_rdata_b | input | 32 | Register file read data, second port |
| rd_en_a | output | 1 | Read enable, first port |
| rd_en_b | output | 1 | Read enable, second port |
| sel_a | output | 3 | First ALU input select code |
| sel_b | output | 3 | Second ALU input select code |
| op_a | output | 32 | First operand value to the ALU |
| op_b | output | 32 | Second operand value to the ALU |
| read_count | output | 32 | Total register file reads issued |

## Verification
A wrong tag or a stale valid bit in the history shows up in the same cycle as a wrong select code or a missing read enable. A wrong held value shows up as an operand that differs from the register file contents. The bench therefore compares every operand against its own copy of the register file, so any stale reuse after a write appears on the next instruction that names that register. Counter faults show up one cycle after the read that was miscounted, and the fixed sequence pins down the totals for each build variant.

// File: rtl/orr_pkg.sv
package orr_pkg;

    // Select codes driven to each ALU-input multiplexer
    typedef enum logic [2:0] {
        SEL_RF      = 3'd0,
        SEL_PREV    = 3'd1,
        SEL_PREV_X  = 3'd2,
        SEL_BACK2   = 3'd3,
        SEL_ZERO    = 3'd4,
        SEL_BACK2_X = 3'd5
    } sel_e;

    // Candidate ordering, which is also the reuse priority
    localparam int unsigned CAND_PREV    = 0;
    localparam int unsigned CAND_PREV_X  = 1;
    localparam int unsigned CAND_BACK2   = 2;
    localparam int unsigned CAND_BACK2_X = 3;
    localparam int unsigned NCAND        = 4;

endpackage

// File: rtl/orr_port_match.sv
module orr_port_match
    import orr_pkg::*;
#(
    parameter int unsigned AW       = 5,
    parameter bit          EN_SWAP  = 1'b1,
    parameter bit          EN_BACK2 = 1'b1
) (
    input  logic          valid,
    input  logic          use_src,
    input  logic [AW-1:0] src,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          cand_vld [NCAND],
    input  logic [AW-1:0] cand_tag [NCAND],
    output sel_e          sel,
    output logic          rd_en
);

    logic             wr_hit;
    logic [NCAND-1:0] hit;
    logic [NCAND-1:0] allow;
    logic [NCAND-1:0] usable;

    assign wr_hit = wr_en && (wr_addr == src);

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        assign hit[c] = cand_vld[c] && (cand_tag[c] == src) && !wr_hit;
    end

    assign allow[CAND_PREV]    = 1'b1;
    assign allow[CAND_PREV_X]  = EN_SWAP;
    assign allow[CAND_BACK2]   = EN_BACK2;
    assign allow[CAND_BACK2_X] = EN_BACK2;
    assign usable              = hit & allow;

    always_comb begin
        if (!valid || !use_src || (src == '0)) begin
            sel = SEL_ZERO;
        end else if (usable[CAND_PREV]) begin
            sel = SEL_PREV;
        end else if (usable[CAND_PREV_X]) begin
            sel = SEL_PREV_X;
        end else if (usable[CAND_BACK2]) begin
            sel = SEL_BACK2;
        end else if (usable[CAND_BACK2_X]) begin
            sel = SEL_BACK2_X;
        end else begin
            sel = SEL_RF;
        end
    end

    assign rd_en = (sel == SEL_RF);

endmodule

// File: rtl/orr_operand_mux.sv
module orr_operand_mux
    import orr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  sel_e          sel,
    input  logic [DW-1:0] rf_rdata,
    input  logic [DW-1:0] cand_val [NCAND],
    output logic [DW-1:0] op
);

    always_comb begin
        unique case (sel)
            SEL_RF:      op = rf_rdata;
            SEL_PREV:    op = cand_val[CAND_PREV];
            SEL_PREV_X:  op = cand_val[CAND_PREV_X];
            SEL_BACK2:   op = cand_val[CAND_BACK2];
            SEL_BACK2_X: op = cand_val[CAND_BACK2_X];
            default:     op = '0;
        endcase
    end

endmodule

// File: rtl/orr_read_counter.sv
module orr_read_counter #(
    parameter int unsigned CW    = 32,
    parameter int unsigned PORTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] rd_en,
    output logic [CW-1:0]    count
);

    localparam int unsigned SW = $clog2(PORTS + 1);

    logic [CW-1:0] count_d, count_q;
    logic [SW-1:0] step;

    always_comb begin
        step = '0;
        for (int i = 0; i < PORTS; i++) begin
            step = step + SW'(rd_en[i]);
        end
        count_d = count_q + CW'(step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/orr_read_ctrl.sv
module orr_read_ctrl
    import orr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RF_ENTRIES = 32,
    parameter int unsigned CNT_W      = 32,
    parameter bit          EN_SWAP    = 1'b1,
    parameter bit          EN_BACK2   = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          use_a,
    input  logic [$clog2(RF_ENTRIES)-1:0] src_a,
    input  logic                          use_b,
    input  logic [$clog2(RF_ENTRIES)-1:0] src_b,
    input  logic                          wr_en,
    input  logic [$clog2(RF_ENTRIES)-1:0] wr_addr,
    input  logic [DATA_W-1:0]             rf_rdata_a,
    input  logic [DATA_W-1:0]             rf_rdata_b,
    output logic                          rd_en_a,
    output logic                          rd_en_b,
    output logic [2:0]                    sel_a,
    output logic [2:0]                    sel_b,
    output logic [DATA_W-1:0]             op_a,
    output logic [DATA_W-1:0]             op_b,
    output logic [CNT_W-1:0]              read_count
);

    localparam int unsigned AW    = $clog2(RF_ENTRIES);
    localparam int unsigned NPORT = 2;
    localparam int unsigned DEPTH = 2;

    typedef struct packed {
        logic [AW-1:0]     tag;
        logic              vld;
        logic [DATA_W-1:0] val;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0][NPORT-1:0] slot;
    } state_t;

    state_t state_d, state_q;

    logic [AW-1:0]     src_w   [NPORT];
    logic              use_w   [NPORT];
    logic [DATA_W-1:0] rdata_w [NPORT];
    sel_e              sel_w   [NPORT];
    logic [DATA_W-1:0] op_w    [NPORT];
    logic [NPORT-1:0]  rd_w;

    assign src_w[0]   = src_a;
    assign src_w[1]   = src_b;
    assign use_w[0]   = use_a;
    assign use_w[1]   = use_b;
    assign rdata_w[0] = rf_rdata_a;
    assign rdata_w[1] = rf_rdata_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int unsigned OTHER = NPORT - 1 - p;

        logic              c_vld [NCAND];
        logic [AW-1:0]     c_tag [NCAND];
        logic [DATA_W-1:0] c_val [NCAND];

        assign c_vld[CAND_PREV]    = state_q.slot[0][p].vld;
        assign c_tag[CAND_PREV]    = state_q.slot[0][p].tag;
        assign c_val[CAND_PREV]    = state_q.slot[0][p].val;
        assign c_vld[CAND_PREV_X]  = state_q.slot[0][OTHER].vld;
        assign c_tag[CAND_PREV_X]  = state_q.slot[0][OTHER].tag;
        assign c_val[CAND_PREV_X]  = state_q.slot[0][OTHER].val;
        assign c_vld[CAND_BACK2]   = state_q.slot[1][p].vld;
        assign c_tag[CAND_BACK2]   = state_q.slot[1][p].tag;
        assign c_val[CAND_BACK2]   = state_q.slot[1][p].val;
        assign c_vld[CAND_BACK2_X] = state_q.slot[1][OTHER].vld;
        assign c_tag[CAND_BACK2_X] = state_q.slot[1][OTHER].tag;
        assign c_val[CAND_BACK2_X] = state_q.slot[1][OTHER].val;

        orr_port_match #(
            .AW       (AW),
            .EN_SWAP  (EN_SWAP),
            .EN_BACK2 (EN_BACK2)
        ) u_match (
            .valid    (in_valid),
            .use_src  (use_w[p]),
            .src      (src_w[p]),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .cand_vld (c_vld),
            .cand_tag (c_tag),
            .sel      (sel_w[p]),
            .rd_en    (rd_w[p])
        );

        orr_operand_mux #(
            .DW (DATA_W)
        ) u_mux (
            .sel      (sel_w[p]),
            .rf_rdata (rdata_w[p]),
            .cand_val (c_val),
            .op       (op_w[p])
        );
    end

    // Next-state: drop copies hit by a write, then shift on a valid instruction
    always_comb begin
        state_d = state_q;
        for (int d = 0; d < DEPTH; d++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (wr_en && (state_d.slot[d][p].tag == wr_addr)) begin
                    state_d.slot[d][p].vld = 1'b0;
                end
            end
        end
        if (in_valid) begin
            for (int d = DEPTH - 1; d > 0; d--) begin
                state_d.slot[d] = state_d.slot[d-1];
            end
            for (int p = 0; p < NPORT; p++) begin
                state_d.slot[0][p].tag = src_w[p];
                state_d.slot[0][p].val = op_w[p];
                state_d.slot[0][p].vld = use_w[p] && (src_w[p] != '0)
                                         && !(wr_en && (wr_addr == src_w[p]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    orr_read_counter #(
        .CW    (CNT_W),
        .PORTS (NPORT)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_w),
        .count (read_count)
    );

    assign rd_en_a = rd_w[0];
    assign rd_en_b = rd_w[1];
    assign sel_a   = sel_w[0];
    assign sel_b   = sel_w[1];
    assign op_a    = op_w[0];
    assign op_b    = op_w[1];

endmodule

// File: rtl/orr_read_ctrl_chk.sv
module orr_read_ctrl_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          use_a,
    input logic [AW-1:0] src_a,
    input logic          use_b,
    input logic [AW-1:0] src_b,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          rd_en_a,
    input logic          rd_en_b,
    input logic [2:0]    sel_a,
    input logic [2:0]    sel_b,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [CW-1:0] read_count
);

    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    AST_BUBBLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!rd_en_a && !rd_en_b)); // R8

    AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!use_a || src_a == '0)) |-> (!rd_en_a && op_a == '0 && sel_a == 3'd4)); // R2

    AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!use_b || src_b == '0)) |-> (!rd_en_b && op_b == '0 && sel_b == 3'd4)); // R2

    AST_WRITE_FORCES_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_a && src_a != '0 && wr_en && wr_addr == src_a) |-> rd_en_a); // R7

    AST_WRITE_FORCES_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_b && src_b != '0 && wr_en && wr_addr == src_b) |-> rd_en_b); // R7

    AST_PREV_REUSE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (started && in_valid && $past(in_valid) && use_a && $past(use_a) && src_a != '0
         && src_a == $past(src_a) && !(wr_en && wr_addr == src_a)
         && !($past(wr_en) && $past(wr_addr) == src_a))
        |-> (sel_a == 3'd1 && !rd_en_a && op_a == $past(op_a))); // R3

    AST_PREV_REUSE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (started && in_valid && $past(in_valid) && use_b && $past(use_b) && src_b != '0
         && src_b == $past(src_b) && !(wr_en && wr_addr == src_b)
         && !($past(wr_en) && $past(wr_addr) == src_b))
        |-> (sel_b == 3'd1 && !rd_en_b && op_b == $past(op_b))); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> (read_count == $past(read_count)
                     + {{(CW-1){1'b0}}, $past(rd_en_a)}
                     + {{(CW-1){1'b0}}, $past(rd_en_b)})); // R9

endmodule

bind orr_read_ctrl orr_read_ctrl_chk #(
    .AW (AW),
    .DW (DATA_W),
    .CW (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .use_a      (use_a),
    .src_a      (src_a),
    .use_b      (use_b),
    .src_b      (src_b),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en_a    (rd_en_a),
    .rd_en_b    (rd_en_b),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .op_a       (op_a),
    .op_b       (op_b),
    .read_count (read_count)
);

// File: tb/orr_read_ctrl_tb.sv
`timescale 1ns/1ps
module orr_read_ctrl_tb;

    localparam int NV = 3; // 0: full, 1: same-port only, 2: same-port + swap

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        in_valid = 0, use_a = 0, use_b = 0, wr_en = 0;
    logic [4:0]  src_a = 0, src_b = 0, wr_addr = 0;
    logic [31:0] rf [32];
    logic [31:0] rf_rdata_a, rf_rdata_b;
    assign rf_rdata_a = rf[src_a];
    assign rf_rdata_b = rf[src_b];

    logic        rd_a_w [NV];
    logic        rd_b_w [NV];
    logic [2:0]  sel_a_w [NV];
    logic [2:0]  sel_b_w [NV];
    logic [31:0] op_a_w [NV];
    logic [31:0] op_b_w [NV];
    logic [31:0] cnt_w [NV];

    orr_read_ctrl #(.EN_SWAP(1'b1), .EN_BACK2(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_a(use_a), .src_a(src_a),
        .use_b(use_b), .src_b(src_b), .wr_en(wr_en), .wr_addr(wr_addr),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rd_en_a(rd_a_w[0]),
        .rd_en_b(rd_b_w[0]), .sel_a(sel_a_w[0]), .sel_b(sel_b_w[0]), .op_a(op_a_w[0]),
        .op_b(op_b_w[0]), .read_count(cnt_w[0]));

    orr_read_ctrl #(.EN_SWAP(1'b0), .EN_BACK2(1'b0)) u_dut_r (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_a(use_a), .src_a(src_a),
        .use_b(use_b), .src_b(src_b), .wr_en(wr_en), .wr_addr(wr_addr),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rd_en_a(rd_a_w[1]),
        .rd_en_b(rd_b_w[1]), .sel_a(sel_a_w[1]), .sel_b(sel_b_w[1]), .op_a(op_a_w[1]),
        .op_b(op_b_w[1]), .read_count(cnt_w[1]));

    orr_read_ctrl #(.EN_SWAP(1'b1), .EN_BACK2(1'b0)) u_dut_rs (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_a(use_a), .src_a(src_a),
        .use_b(use_b), .src_b(src_b), .wr_en(wr_en), .wr_addr(wr_addr),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b), .rd_en_a(rd_a_w[2]),
        .rd_en_b(rd_b_w[2]), .sel_a(sel_a_w[2]), .sel_b(sel_b_w[2]), .op_a(op_a_w[2]),
        .op_b(op_b_w[2]), .read_count(cnt_w[2]));

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    bit  mvld [NV][2][2];
    int  mtag [NV][2][2];
    int  mcnt [NV];

    task automatic check(input bit ok, input string req, input string what,
                         input int v, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s variant=%0d act=%0h exp=%0h", req, what, v, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        case (code)
            0:       return "R7";
            1:       return "R3";
            2:       return "R4";
            3, 5:    return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic bit mhit(input int v, input int d, input int p, input int s,
                                input bit we, input int wa);
        return mvld[v][d][p] && mtag[v][d][p] == s && !(we && wa == s);
    endfunction

    function automatic int exp_sel(input int v, input int p, input bit vld, input bit u,
                                   input int s, input bit we, input int wa);
        int q = 1 - p;
        if (!vld || !u || s == 0) return 4;
        if (mhit(v, 0, p, s, we, wa)) return 1;
        if (v != 1 && mhit(v, 0, q, s, we, wa)) return 2;
        if (v == 0 && mhit(v, 1, p, s, we, wa)) return 3;
        if (v == 0 && mhit(v, 1, q, s, we, wa)) return 5;
        return 0;
    endfunction

    task automatic model_reset();
        for (int v = 0; v < NV; v++) begin
            mcnt[v] = 0;
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < 2; p++) begin
                    mvld[v][d][p] = 0;
                    mtag[v][d][p] = 0;
                end
        end
    endtask

    task automatic step(input bit vld, input bit ua, input int sa, input bit ub, input int sb,
                        input bit we, input int wa, input string tag);
        int          ea, eb;
        logic [31:0] wdata;
        int          s [2];
        bit          u [2];
        @(negedge clk);
        in_valid = vld; use_a = ua; src_a = 5'(sa); use_b = ub; src_b = 5'(sb);
        wr_en = we; wr_addr = 5'(wa);
        wdata = $urandom;
        #1;
        s[0] = sa; s[1] = sb; u[0] = ua; u[1] = ub;
        for (int v = 0; v < NV; v++) begin
            check(cnt_w[v] == 32'(mcnt[v]), "R9", "read_count", v, cnt_w[v], mcnt[v]);
            ea = exp_sel(v, 0, vld, ua, sa, we, wa);
            eb = exp_sel(v, 1, vld, ub, sb, we, wa);
            check(sel_a_w[v] == 3'(ea), (tag == "") ? req_of(ea) : tag, "sel_a", v, sel_a_w[v], ea);
            check(sel_b_w[v] == 3'(eb), (tag == "") ? req_of(eb) : tag, "sel_b", v, sel_b_w[v], eb);
            check(rd_a_w[v] == (ea == 0), req_of(ea), "rd_en_a", v, rd_a_w[v], ea == 0);
            check(rd_b_w[v] == (eb == 0), req_of(eb), "rd_en_b", v, rd_b_w[v], eb == 0);
            check(op_a_w[v] == ((ea == 4) ? 32'd0 : rf[sa]), req_of(ea), "op_a", v, op_a_w[v],
                  (ea == 4) ? 32'd0 : rf[sa]);
            check(op_b_w[v] == ((eb == 4) ? 32'd0 : rf[sb]), req_of(eb), "op_b", v, op_b_w[v],
                  (eb == 4) ? 32'd0 : rf[sb]);
            mcnt[v] += int'(ea == 0) + int'(eb == 0);
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < 2; p++)
                    if (we && mtag[v][d][p] == wa) mvld[v][d][p] = 0;
            if (vld) begin
                for (int p = 0; p < 2; p++) begin
                    mvld[v][1][p] = mvld[v][0][p];
                    mtag[v][1][p] = mtag[v][0][p];
                    mtag[v][0][p] = s[p];
                    mvld[v][0][p] = u[p] && s[p] != 0 && !(we && wa == s[p]);
                end
            end
        end
        @(posedge clk);
        #1;
        if (we && wa != 0) rf[wa] = wdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; wr_en = 0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 32'd0 : $urandom;
        model_reset();
        do_reset();

        // R1: counter cleared, first instruction reads everything
        @(negedge clk);
        for (int v = 0; v < NV; v++) check(cnt_w[v] == 0, "R1", "count after reset", v, cnt_w[v], 0);
        step(1, 1, 17, 1, 9, 0, 0, "R1");

        // R10: fixed sequence from a clean history
        do_reset();
        step(1, 1, 17, 1, 9, 0, 0, "");
        step(1, 1, 17, 1, 9, 0, 0, "");
        step(1, 1, 9, 1, 17, 0, 0, "");
        step(1, 1, 17, 1, 9, 0, 0, "");
        step(1, 1, 17, 0, 0, 0, 0, "");
        step(1, 1, 17, 1, 9, 0, 0, "");
        step(0, 0, 0, 0, 0, 0, 0, "");
        check(cnt_w[0] == 2, "R10", "total reads full", 0, cnt_w[0], 2);
        check(cnt_w[1] == 7, "R10", "total reads same-port", 1, cnt_w[1], 7);
        check(cnt_w[2] == 3, "R10", "total reads swap", 2, cnt_w[2], 3);

        // R8: bubbles keep the history, a write during a bubble still removes a copy
        step(1, 1, 3, 1, 4, 0, 0, "");
        step(0, 1, 3, 1, 4, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 4, "R8");
        step(1, 1, 3, 1, 4, 0, 0, "R8");

        // R6: previous-swapped beats two-back same-port
        step(1, 1, 4, 1, 6, 0, 0, "");
        step(1, 1, 3, 1, 4, 0, 0, "");
        step(1, 1, 4, 1, 5, 0, 0, "R6");
        step(1, 1, 4, 1, 4, 0, 0, "R6");

        // R7: same-cycle write and write after capture
        step(1, 1, 12, 1, 13, 0, 0, "");
        step(1, 1, 12, 1, 13, 1, 12, "R7");
        step(1, 1, 12, 1, 13, 0, 0, "R7");
        step(1, 1, 12, 1, 13, 1, 13, "R7");

        // R2: zero register and unused sources
        step(1, 1, 0, 0, 7, 0, 0, "R2");

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 8) != 0, ($urandom % 10) != 0, $urandom % 6,
                 ($urandom % 10) != 0, $urandom % 6,
                 ($urandom % 4) == 0, $urandom % 6, "");
        end
        step(0, 0, 0, 0, 0, 0, 0, "");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule